// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block takes up to six asynchronous external interrupt pins and turns each one into a clean, maskable request for a downstream interrupt controller. Each pin is first brought into the clock domain, then detected either as a level or as an edge according to its own trigger settings. Edge events are held in a sticky flag until software acknowledges them. A per-pin enable gates the result onto a request output, and a combined request is the OR of all pin requests.

Software programs the trigger settings through two 32-bit configuration words. Pins 0 to 3 live in word 0 and pins 4 and 5 live in word 1. Inside a word, the slot a pin uses is its number modulo 4. Each pin has three trigger bits: level-sense, polarity and any-edge. Together they select one of five modes. Each pin also has an enable bit and an acknowledge bit. The acknowledge bit is a write-only pulse.

Top module: `xirq_trig_unit`

## Requirements
- R1: After reset, every configuration bit is 0, `cfg_rdata` reads 0 for both words, and `irq_o` and `irq_any_o` are 0.
- R2: Word select 0 holds pins 0..3 and word select 1 holds pins 4..5, each in slot (pin mod 4). Within a word, slot i sits at these bits: acknowledge 0+i, enable 4+i, polarity 8+i, level-sense 12+i, any-edge 16+i. Bits 31:20 read as 0, and so do the slots of word 1 that have no pin. A word keeps its value unless it is written.
- R3: Acknowledge bits are never stored and always read back as 0.
- R4: Level-high mode is level-sense=1 and polarity=1. The pin request equals the synchronised pin, so a pin value sampled at a clock edge shows on `irq_o` after the next edge.
- R5: Level-low mode is level-sense=1 and polarity=0. The pin request is the inverse of the synchronised pin, with the same latency as R4.
- R6: Rising mode is level-sense=0, polarity=1 and any-edge=0. A 0-to-1 pin change sets a sticky flag. The flag becomes visible two edges after the edge that first samples the new level.
- R7: Falling mode is all three trigger bits at 0. A 1-to-0 pin change sets the sticky flag, with the same timing as R6.
- R8: Any-edge mode is any-edge=1 with level-sense=0. Both directions of change set the sticky flag. Level-sense takes priority over any-edge, and any-edge takes priority over polarity.
- R9: A write that carries a 1 in a pin's acknowledge bit clears that pin's sticky flag at that edge. If an edge event is detected in the same cycle, the event wins and the flag stays set.
- R10: An enable bit of 0 forces that pin's `irq_o` to 0. Edge events are still captured while the pin is disabled, and they appear once the pin is enabled.
- R11: While a pin is in a level mode its sticky flag is held at 0, so a later switch to an edge mode starts with no pending event.
- R12: `irq_any_o` is 1 exactly when at least one bit of `irq_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 6 | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word selected for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 1 | Word selected for readback |
| cfg_rdata | output | 32 | Readback of the selected word |
| irq_o | output | 6 | Enabled request per pin |
| irq_any_o | output | 1 | OR of all pin requests |

## Verification
The assertions assume that the write strobe, the word select and the data change only between clock edges. They also assume that the acknowledge pulses come only from writes. The pins may be fully asynchronous, because every check looks at the synchronised copies.

The bench drives every input on the falling clock edge. It holds the pins low and issues no writes while the internal reset is released. Random stimulus then mixes pin toggles with writes of random words, including acknowledges that coincide with edge events. Directed phases cover each trigger mode, readback masking and mode switching.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  // pins per configuration word; the slot layout depends on it
  localparam int SLOTS   = 4;
  localparam int CLR_LSB = 0;
  localparam int ENA_LSB = CLR_LSB + SLOTS;
  localparam int POL_LSB = ENA_LSB + SLOTS;
  localparam int LVL_LSB = POL_LSB + SLOTS;
  localparam int ANY_LSB = LVL_LSB + SLOTS;

  typedef struct packed {
    logic lvl;  // level-sense
    logic pol;  // polarity: 1 = high / rising
    logic any;  // any-edge
    logic ena;  // request enable
  } pin_cfg_t;

  function automatic int sel_width(input int words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction
endpackage

// File: rtl/xirq_cfg_regs.sv
module xirq_cfg_regs
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [DATA_W-1:0]       cfg_wdata,
  input  logic [SEL_W-1:0]        cfg_rsel,
  output logic [DATA_W-1:0]       cfg_rdata,
  output pin_cfg_t [NUM_PINS-1:0] cfg_o,
  output logic [NUM_PINS-1:0]     ack_o
);
  pin_cfg_t [NUM_PINS-1:0] cfg_q, cfg_d;
  logic     [NUM_PINS-1:0] hit;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD = p / SLOTS;
    localparam int SLOT = p % SLOTS;
    assign hit[p]   = cfg_we && (cfg_sel == SEL_W'(WORD));
    assign ack_o[p] = hit[p] && cfg_wdata[CLR_LSB+SLOT];

    always_comb begin
      cfg_d[p] = cfg_q[p];
      if (hit[p]) begin
        cfg_d[p].lvl = cfg_wdata[LVL_LSB+SLOT];
        cfg_d[p].pol = cfg_wdata[POL_LSB+SLOT];
        cfg_d[p].any = cfg_wdata[ANY_LSB+SLOT];
        cfg_d[p].ena = cfg_wdata[ENA_LSB+SLOT];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[p] <= '0;
      else if (hit[p]) cfg_q[p] <= cfg_d[p];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (cfg_rsel == SEL_W'(p / SLOTS)) begin
        cfg_rdata[ENA_LSB + p % SLOTS] = cfg_q[p].ena;
        cfg_rdata[POL_LSB + p % SLOTS] = cfg_q[p].pol;
        cfg_rdata[LVL_LSB + p % SLOTS] = cfg_q[p].lvl;
        cfg_rdata[ANY_LSB + p % SLOTS] = cfg_q[p].any;
      end
    end
  end

  assign cfg_o = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/xirq_pin_cond.sv
module xirq_pin_cond
  import xirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_async,
  input  pin_cfg_t cfg,
  input  logic     ack,
  output logic     irq
);
  logic s1_q, s2_q, s3_q, flag_q;
  logic flag_d, rise, fall, evt, lvl_req, pend;

  always_comb begin
    rise = s2_q & ~s3_q;
    fall = ~s2_q & s3_q;
    if (cfg.any)      evt = rise | fall;
    else if (cfg.pol) evt = rise;
    else              evt = fall;

    if (cfg.lvl)  flag_d = 1'b0;
    else if (evt) flag_d = 1'b1;
    else if (ack) flag_d = 1'b0;
    else          flag_d = flag_q;

    lvl_req = cfg.pol ? s2_q : ~s2_q;
    pend    = cfg.lvl ? lvl_req : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      s1_q   <= pin_async;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      flag_q <= flag_d;
    end
  end

  assign irq = pend & cfg.ena;

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.lvl && evt) |=> flag_q); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !flag_q); // R9
  AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.lvl |=> !flag_q); // R11
endmodule

// File: rtl/xirq_trig_unit.sv
module xirq_trig_unit
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 32,
  localparam int WORDS   = (NUM_PINS + SLOTS - 1) / SLOTS,
  localparam int SEL_W   = sel_width(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic [SEL_W-1:0]    cfg_rsel,
  output logic [DATA_W-1:0]   cfg_rdata,
  output logic [NUM_PINS-1:0] irq_o,
  output logic                irq_any_o
);
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  pin_cfg_t [NUM_PINS-1:0] cfg;
  logic     [NUM_PINS-1:0] ack;
  logic     [NUM_PINS-1:0] ena_vec;

  xirq_cfg_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rsel  (cfg_rsel),
    .cfg_rdata (cfg_rdata),
    .cfg_o     (cfg),
    .ack_o     (ack)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cond
    assign ena_vec[p] = cfg[p].ena;
    xirq_pin_cond cond_i (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .pin_async (pin_i[p]),
      .cfg       (cfg[p]),
      .ack       (ack[p]),
      .irq       (irq_o[p])
    );
  end

  assign irq_any_o = |irq_o;

  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_o & ~ena_vec) == '0); // R10
endmodule

// File: tb/xirq_trig_unit_tb_top.sv
module xirq_trig_unit_tb_top;
  localparam int NP = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NP-1:0] pin_i;
  logic        cfg_we;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic        cfg_rsel;
  logic [31:0] cfg_rdata;
  logic [NP-1:0] irq_o;
  logic        irq_any_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  bit [NP-1:0] m_s1, m_s2, m_s3, m_flag, m_lvl, m_pol, m_any, m_ena;

  always #10 clk = ~clk;

  xirq_trig_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .irq_o(irq_o), .irq_any_o(irq_any_o)
  );

  function automatic bit [NP-1:0] exp_irq();
    bit [NP-1:0] r;
    for (int p = 0; p < NP; p++) begin
      bit pend;
      pend = m_lvl[p] ? (m_pol[p] ? m_s2[p] : ~m_s2[p]) : m_flag[p];
      r[p] = pend & m_ena[p];
    end
    return r;
  endfunction

  function automatic bit [31:0] exp_rd(input bit s);
    bit [31:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      int p = int'(s) * 4 + i;
      if (p < NP) begin
        r[4+i]  = m_ena[p];
        r[8+i]  = m_pol[p];
        r[12+i] = m_lvl[p];
        r[16+i] = m_any[p];
      end
    end
    return r;
  endfunction

  task automatic model_edge(input bit [NP-1:0] pins, input bit we, input bit sel,
                            input bit [31:0] wd);
    bit [NP-1:0] nf;
    for (int p = 0; p < NP; p++) begin
      bit rise, fall, evt, ack;
      rise = m_s2[p] & ~m_s3[p];
      fall = ~m_s2[p] & m_s3[p];
      evt  = m_any[p] ? (rise | fall) : (m_pol[p] ? rise : fall);
      ack  = we && (sel == p / 4) && wd[p % 4];
      nf[p] = m_lvl[p] ? 1'b0 : (evt ? 1'b1 : (ack ? 1'b0 : m_flag[p]));
    end
    m_flag = nf;
    m_s3 = m_s2;
    m_s2 = m_s1;
    m_s1 = pins;
    if (we) begin
      for (int p = 0; p < NP; p++) begin
        if (sel == p / 4) begin
          m_ena[p] = wd[4  + p % 4];
          m_pol[p] = wd[8  + p % 4];
          m_lvl[p] = wd[12 + p % 4];
          m_any[p] = wd[16 + p % 4];
        end
      end
    end
  endtask

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // compare outputs, then drive one cycle of inputs and advance the model
  task automatic step(input bit [NP-1:0] pins, input bit we, input bit sel,
                      input bit [31:0] wd, input bit rs);
    bit [NP-1:0] ei;
    @(negedge clk);
    ei = exp_irq();
    chk("irq_o", 32'(irq_o), 32'(ei));
    chk("irq_any_o (R12)", 32'(irq_any_o), 32'(|ei));
    chk("cfg_rdata", cfg_rdata, exp_rd(cfg_rsel));
    pin_i = pins; cfg_we = we; cfg_sel = sel; cfg_wdata = wd; cfg_rsel = rs;
    @(posedge clk);
    #1 model_edge(pins, we, sel, wd);
  endtask

  task automatic idle(input bit [NP-1:0] pins, input int n);
    for (int k = 0; k < n; k++) step(pins, 1'b0, 1'b0, 32'h0, k[0]);
  endtask

  task automatic wr(input bit sel, input bit [31:0] wd, input bit [NP-1:0] pins);
    step(pins, 1'b1, sel, wd, sel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired during %s: actual hung expected done", tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [NP-1:0] pv;
    void'($urandom(32'd1234));
    rst_n = 1'b0; pin_i = '0; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; cfg_rsel = 0;
    m_s1 = '0; m_s2 = '0; m_s3 = '0; m_flag = '0;
    m_lvl = '0; m_pol = '0; m_any = '0; m_ena = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    tag = "R1";
    chk("irq_o at reset", 32'(irq_o), 32'h0);
    chk("irq_any_o at reset", 32'(irq_any_o), 32'h0);
    chk("word0 at reset", cfg_rdata, 32'h0);
    rst_n = 1'b1;
    idle('0, 5);

    // R2/R3: layout, reserved and acknowledge bits read 0
    tag = "R2";
    wr(1'b0, 32'hFFFF_FFFF, '0);
    step('0, 1'b0, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    chk("R3 word0 readback", cfg_rdata, 32'h000F_FFF0);
    wr(1'b1, 32'hFFFF_FFFF, '0);
    step('0, 1'b0, 1'b0, 32'h0, 1'b1);
    @(negedge clk);
    chk("R2 word1 readback", cfg_rdata, 32'h0003_3330);
    wr(1'b0, 32'h0, '0);
    wr(1'b1, 32'h0, '0);
    idle('0, 4);

    // R4 level-high, all pins enabled
    tag = "R4";
    wr(1'b0, 32'h0000_FFF0, '0);
    wr(1'b1, 32'h0000_3330, '0);
    idle(6'b101010, 3); idle(6'b010101, 3); idle('0, 3);
    // R5 level-low
    tag = "R5";
    wr(1'b0, 32'h0000_F0F0, '0);
    wr(1'b1, 32'h0000_3030, '0);
    idle(6'b110011, 3); idle('0, 3);
    // R6 rising, then acknowledge all
    tag = "R6";
    wr(1'b0, 32'h0000_0FF0, '0);
    wr(1'b1, 32'h0000_0330, '0);
    idle('1, 4); idle('0, 4);
    wr(1'b0, 32'h0000_0FFF, '0);
    wr(1'b1, 32'h0000_0333, '0);
    idle('0, 3);
    // R7 falling
    tag = "R7";
    wr(1'b0, 32'h0000_00F0, '1);
    wr(1'b1, 32'h0000_0030, '1);
    idle('1, 4); idle('0, 4);
    // R8 any-edge (polarity also set: any-edge dominates)
    tag = "R8";
    wr(1'b0, 32'h000F_0FFF, '0);
    wr(1'b1, 32'h0003_0333, '0);
    idle('1, 4);
    wr(1'b0, 32'h000F_0FFF, '1);
    wr(1'b1, 32'h0003_0333, '1);
    idle('0, 4);
    // R9 acknowledge while edges keep arriving
    tag = "R9";
    for (int k = 0; k < 12; k++) wr(k[0], 32'h000F_0FFF, k[1] ? 6'h3F : 6'h00);
    idle('0, 4);
    // R10 disabled pins still capture edges
    tag = "R10";
    wr(1'b0, 32'h0000_0F0F, '0);
    wr(1'b1, 32'h0000_0303, '0);
    idle('1, 4); idle('0, 2);
    wr(1'b0, 32'h0000_0FF0, '0);
    wr(1'b1, 32'h0000_0330, '0);
    idle('0, 3);
    // R11 level mode clears the flag; switch back to edge mode
    tag = "R11";
    wr(1'b0, 32'h0000_F0F0, '1);
    wr(1'b1, 32'h0000_3030, '1);
    idle('1, 3);
    wr(1'b0, 32'h0000_0FF0, '1);
    wr(1'b1, 32'h0000_0330, '1);
    idle('1, 4);

    // random mix covering R2..R12
    tag = "R9/R12 random";
    pv = '0;
    for (int k = 0; k < 4000; k++) begin
      bit we;
      if ($urandom_range(3) == 0) pv = pv ^ 6'($urandom);
      we = ($urandom_range(7) == 0);
      step(pv, we, 1'($urandom), {12'h0, 20'($urandom)}, 1'($urandom));
    end
    idle('0, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule